// File: doc/BRIEF.md
# Software-Controlled Priority Interrupt Controller

This block arbitrates among a large set of numbered interrupt levels for a processor. Every level keeps three bits of state: an enable bit, a pending bit and an active bit. Hardware request lines and privileged software commands set these bits. Combinational resolution logic then finds the most urgent level that is pending and enabled and that also outranks every level now in service. It presents that level and its vector address, which is a fixed base plus four times the level number. The processor accepts the offered level with an acknowledge. The level then leaves the pending state and becomes active until software deactivates it.

Level 0, the power-fail/restart level, and one more level, the system-override level, ignore software. Their enable bits are always set, and no command can request, activate or deactivate them. Once either one is granted, it stays in service until reset. A control command issued without privilege has no effect. It produces a one-cycle privilege-violation trap pulse instead.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every level other than the two protected ones is disabled, no level is pending or active, irq_valid is 0 and priv_trap is 0. A reset in the middle of a run clears all pending and active state.
- R2: A privileged command with cmd_valid high acts on cmd_level at the clock edge where it is sampled. The cmd_op codes are 1 enable, 2 disable, 3 request (set pending), 4 activate and 5 deactivate. Codes 0, 6 and 7 change nothing.
- R3: A high bit of hw_req sets the pending bit of that level in the same way as a software request.
- R4: A pending bit is not cleared by disabling its level. When the level is enabled again, it is offered.
- R5: irq_valid is 1 exactly when some level is pending and enabled and has a lower number than every active level. Level 0 has the highest priority. irq_level is the lowest-numbered such level.
- R6: irq_vector equals VEC_BASE + 4 * irq_level.
- R7: irq_ack sampled while irq_valid is 1 clears the offered level's pending bit and sets its active bit. This blocks all lower-priority levels until a deactivate command clears that active bit.
- R8: A command with cmd_priv low and an op code from 1 to 5 changes no state and raises priv_trap for exactly the following cycle. Codes 0, 6 and 7 raise no trap.
- R9: Level 0 and level OVR_LEVEL (default 1) are always enabled. They ignore every privileged command and issue no trap for one, but their hardware request lines still set their pending bits.
- R10: A protected level, once acknowledged, stays active until reset and blocks every other level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_req | input | NUM_LEVELS | Hardware request line per level |
| cmd_valid | input | 1 | A control command is presented |
| cmd_op | input | 3 | Command code (1 enable, 2 disable, 3 request, 4 activate, 5 deactivate) |
| cmd_level | input | LVL_W | Level the command addresses |
| cmd_priv | input | 1 | Issuer is in privileged mode |
| irq_ack | input | 1 | Processor accepts the offered level |
| irq_valid | output | 1 | A level is offered |
| irq_level | output | LVL_W | Offered level number |
| irq_vector | output | ADDR_W | Dedicated vector address of the offered level |
| priv_trap | output | 1 | Privilege-violation trap pulse |

## Verification
The assertions check on every cycle that an unprivileged command raises the trap and leaves the enable and active state untouched. They also check that pending bits are cleared only by a grant, that a grant activates the offered level, and that an offered level is both pending and enabled. The bench scenarios are needed for the priority order among several competing levels and for blocking by active levels, including release by deactivation. They also cover the exact vector arithmetic, the behaviour at the top level number and the immunity of the protected levels. The permanent hold of a protected level and the clearing of state by a mid-run reset are shown in the bench as well.

// File: rtl/pic_pkg.sv
package pic_pkg;

  typedef enum logic [2:0] {
    OP_NOP        = 3'd0,
    OP_ENABLE     = 3'd1,
    OP_DISABLE    = 3'd2,
    OP_REQUEST    = 3'd3,
    OP_ACTIVATE   = 3'd4,
    OP_DEACTIVATE = 3'd5
  } pic_op_e;

  function automatic logic is_ctl_op(input logic [2:0] op);
    return (op >= 3'd1) && (op <= 3'd5);
  endfunction

endpackage

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode
  import pic_pkg::*;
#(
  parameter int NUM_LEVELS = 112,
  parameter int OVR_LEVEL  = 1,
  localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [2:0]            cmd_op,
  input  logic [LVL_W-1:0]      cmd_level,
  input  logic                  cmd_priv,
  output logic [NUM_LEVELS-1:0] set_en,
  output logic [NUM_LEVELS-1:0] clr_en,
  output logic [NUM_LEVELS-1:0] set_pend,
  output logic [NUM_LEVELS-1:0] set_act,
  output logic [NUM_LEVELS-1:0] clr_act,
  output logic                  priv_trap
);

  localparam logic [NUM_LEVELS-1:0] PROT_MASK =
    NUM_LEVELS'(1) | (NUM_LEVELS'(1) << OVR_LEVEL);

  logic [NUM_LEVELS-1:0] hit;
  logic                  trap_n;
  logic                  trap_q;

  generate
    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_sel
      assign hit[g] = cmd_valid && cmd_priv && !PROT_MASK[g] &&
                      (cmd_level == LVL_W'(g));
    end
  endgenerate

  always_comb begin
    set_en   = '0;
    clr_en   = '0;
    set_pend = '0;
    set_act  = '0;
    clr_act  = '0;
    unique case (cmd_op)
      OP_ENABLE:     set_en   = hit;
      OP_DISABLE:    clr_en   = hit;
      OP_REQUEST:    set_pend = hit;
      OP_ACTIVATE:   set_act  = hit;
      OP_DEACTIVATE: clr_act  = hit;
      default:       ;
    endcase
  end

  always_comb begin
    trap_n = cmd_valid && !cmd_priv && is_ctl_op(cmd_op);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trap_q <= 1'b0;
    else        trap_q <= trap_n;
  end

  assign priv_trap = trap_q;

  p_trap_on_unpriv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_priv && (cmd_op >= 3'd1) && (cmd_op <= 3'd5)) |=> priv_trap);

  p_trap_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(priv_trap) |-> $past(cmd_valid && !cmd_priv));

  p_no_decode_unpriv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_priv) |-> ((set_en | clr_en | set_pend | set_act | clr_act) == '0));

endmodule

// File: rtl/pic_level_state.sv
module pic_level_state #(
  parameter int NUM_LEVELS = 112,
  parameter int OVR_LEVEL  = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS-1:0] hw_req,
  input  logic [NUM_LEVELS-1:0] set_en,
  input  logic [NUM_LEVELS-1:0] clr_en,
  input  logic [NUM_LEVELS-1:0] set_pend,
  input  logic [NUM_LEVELS-1:0] set_act,
  input  logic [NUM_LEVELS-1:0] clr_act,
  input  logic [NUM_LEVELS-1:0] grant_mask,
  output logic [NUM_LEVELS-1:0] en_q,
  output logic [NUM_LEVELS-1:0] pend_q,
  output logic [NUM_LEVELS-1:0] act_q
);

  localparam logic [NUM_LEVELS-1:0] PROT_MASK =
    NUM_LEVELS'(1) | (NUM_LEVELS'(1) << OVR_LEVEL);

  logic [NUM_LEVELS-1:0] en_n, pend_n, act_n;
  logic                  upd;

  always_comb begin
    en_n   = ((en_q | set_en) & ~clr_en) | PROT_MASK;
    pend_n = (pend_q & ~grant_mask) | hw_req | set_pend;
    act_n  = ((act_q | grant_mask) | set_act) & ~clr_act;
    upd    = (en_n != en_q) || (pend_n != pend_q) || (act_n != act_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= PROT_MASK;
      pend_q <= '0;
      act_q  <= '0;
    end else if (upd) begin
      en_q   <= en_n;
      pend_q <= pend_n;
      act_q  <= act_n;
    end
  end

  p_pend_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_mask == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  p_grant_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_mask));

endmodule

// File: rtl/pic_priority.sv
module pic_priority #(
  parameter int NUM_LEVELS = 112,
  localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS-1:0] en,
  input  logic [NUM_LEVELS-1:0] pend,
  input  logic [NUM_LEVELS-1:0] act,
  output logic                  found,
  output logic [LVL_W-1:0]      level
);

  logic [NUM_LEVELS-1:0] act_at_or_above;
  logic [NUM_LEVELS-1:0] cand;

  generate
    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_pre
      if (g == 0) begin : g_first
        assign act_at_or_above[g] = act[g];
      end else begin : g_rest
        assign act_at_or_above[g] = act_at_or_above[g-1] | act[g];
      end
    end
  endgenerate

  assign cand = pend & en & ~act_at_or_above;

  always_comb begin
    found = 1'b0;
    level = '0;
    for (int i = NUM_LEVELS - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        level = LVL_W'(i);
      end
    end
  end

  p_offer_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (pend[level] && en[level]));

  p_offer_outranks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> ((act & ((NUM_LEVELS'(1) << level) | ((NUM_LEVELS'(1) << level) - NUM_LEVELS'(1)))) == '0));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int               NUM_LEVELS = 112,
  parameter int               OVR_LEVEL  = 1,
  parameter int               ADDR_W     = 24,
  parameter logic [ADDR_W-1:0] VEC_BASE  = 24'h000100,
  localparam int              LVL_W      = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS-1:0] hw_req,
  input  logic                  cmd_valid,
  input  logic [2:0]            cmd_op,
  input  logic [LVL_W-1:0]      cmd_level,
  input  logic                  cmd_priv,
  input  logic                  irq_ack,
  output logic                  irq_valid,
  output logic [LVL_W-1:0]      irq_level,
  output logic [ADDR_W-1:0]     irq_vector,
  output logic                  priv_trap
);

  logic [NUM_LEVELS-1:0] set_en, clr_en, set_pend, set_act, clr_act;
  logic [NUM_LEVELS-1:0] en_q, pend_q, act_q;
  logic [NUM_LEVELS-1:0] grant_mask;
  logic                  found;
  logic [LVL_W-1:0]      win_level;

  pic_cmd_decode #(.NUM_LEVELS(NUM_LEVELS), .OVR_LEVEL(OVR_LEVEL)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_level(cmd_level), .cmd_priv(cmd_priv),
    .set_en(set_en), .clr_en(clr_en), .set_pend(set_pend),
    .set_act(set_act), .clr_act(clr_act), .priv_trap(priv_trap)
  );

  pic_level_state #(.NUM_LEVELS(NUM_LEVELS), .OVR_LEVEL(OVR_LEVEL)) u_state (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req),
    .set_en(set_en), .clr_en(clr_en), .set_pend(set_pend),
    .set_act(set_act), .clr_act(clr_act), .grant_mask(grant_mask),
    .en_q(en_q), .pend_q(pend_q), .act_q(act_q)
  );

  pic_priority #(.NUM_LEVELS(NUM_LEVELS)) u_prio (
    .clk(clk), .rst_n(rst_n),
    .en(en_q), .pend(pend_q), .act(act_q),
    .found(found), .level(win_level)
  );

  always_comb begin
    grant_mask = '0;
    if (found && irq_ack) grant_mask = NUM_LEVELS'(1) << win_level;
  end

  assign irq_valid  = found;
  assign irq_level  = win_level;
  assign irq_vector = VEC_BASE + {{(ADDR_W-LVL_W-2){1'b0}}, win_level, 2'b00};

  p_unpriv_no_effect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_priv && !(irq_ack && irq_valid)) |=> ($stable(en_q) && $stable(act_q)));

  p_ack_activates_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_valid && !cmd_valid) |=> act_q[$past(irq_level)]);

  p_prot_immune_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_priv && ((cmd_level == '0) || (cmd_level == LVL_W'(OVR_LEVEL)))
     && !(irq_ack && irq_valid)) |=> ($stable(en_q) && $stable(act_q)));

endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;

  localparam int N  = 112;
  localparam int LW = $clog2(N);
  localparam int AW = 24;
  localparam logic [AW-1:0] BASE = 24'h000100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  hw_req = '0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [LW-1:0] cmd_level = '0;
  logic          cmd_priv = 1'b0;
  logic          irq_ack = 1'b0;
  logic          irq_valid;
  logic [LW-1:0] irq_level;
  logic [AW-1:0] irq_vector;
  logic          priv_trap;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl #(.NUM_LEVELS(N), .OVR_LEVEL(1), .ADDR_W(AW), .VEC_BASE(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_level(cmd_level), .cmd_priv(cmd_priv),
    .irq_ack(irq_ack), .irq_valid(irq_valid), .irq_level(irq_level),
    .irq_vector(irq_vector), .priv_trap(priv_trap)
  );

  typedef struct packed {
    logic [2:0] op;
    logic [6:0] lvl;
    logic       priv;
    logic       hw;
    logic [6:0] hwl;
    logic       ack;
    logic       ev;
    logic [6:0] el;
    logic       et;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VT [NV] = '{
    '{3'd1, 7'd10,  1'b1, 1'b0, 7'd0,  1'b0, 1'b0, 7'd0,   1'b0}, // R2 enable 10
    '{3'd3, 7'd10,  1'b1, 1'b0, 7'd0,  1'b0, 1'b1, 7'd10,  1'b0}, // R2 request 10
    '{3'd1, 7'd5,   1'b1, 1'b0, 7'd0,  1'b0, 1'b1, 7'd10,  1'b0}, // R2 enable 5
    '{3'd0, 7'd0,   1'b1, 1'b1, 7'd5,  1'b0, 1'b1, 7'd5,   1'b0}, // R3 hw 5 wins, R5
    '{3'd0, 7'd0,   1'b1, 1'b0, 7'd0,  1'b1, 1'b0, 7'd0,   1'b0}, // R7 ack 5 blocks 10
    '{3'd3, 7'd3,   1'b1, 1'b0, 7'd0,  1'b0, 1'b0, 7'd0,   1'b0}, // R4 request 3 disabled
    '{3'd1, 7'd3,   1'b1, 1'b0, 7'd0,  1'b0, 1'b1, 7'd3,   1'b0}, // R5 3 outranks active 5
    '{3'd2, 7'd3,   1'b0, 1'b0, 7'd0,  1'b0, 1'b1, 7'd3,   1'b1}, // R8 unpriv disable
    '{3'd0, 7'd0,   1'b1, 1'b0, 7'd0,  1'b0, 1'b1, 7'd3,   1'b0}, // R8 trap one cycle
    '{3'd0, 7'd0,   1'b1, 1'b0, 7'd0,  1'b1, 1'b0, 7'd0,   1'b0}, // R7 ack 3
    '{3'd5, 7'd3,   1'b1, 1'b0, 7'd0,  1'b0, 1'b0, 7'd0,   1'b0}, // R7 5 still active
    '{3'd5, 7'd5,   1'b1, 1'b0, 7'd0,  1'b0, 1'b1, 7'd10,  1'b0}, // R7 release
    '{3'd6, 7'd10,  1'b1, 1'b0, 7'd0,  1'b0, 1'b1, 7'd10,  1'b0}, // R2 code 6 nothing
    '{3'd7, 7'd10,  1'b0, 1'b0, 7'd0,  1'b0, 1'b1, 7'd10,  1'b0}, // R8 code 7 no trap
    '{3'd2, 7'd10,  1'b1, 1'b0, 7'd0,  1'b0, 1'b0, 7'd0,   1'b0}, // R4 disable 10
    '{3'd1, 7'd10,  1'b1, 1'b0, 7'd0,  1'b0, 1'b1, 7'd10,  1'b0}, // R4 pending kept
    '{3'd4, 7'd20,  1'b1, 1'b0, 7'd0,  1'b0, 1'b1, 7'd10,  1'b0}, // R2 activate 20
    '{3'd4, 7'd8,   1'b1, 1'b0, 7'd0,  1'b0, 1'b0, 7'd0,   1'b0}, // R5 active 8 blocks
    '{3'd5, 7'd8,   1'b1, 1'b0, 7'd0,  1'b0, 1'b1, 7'd10,  1'b0}, // R2 deactivate 8
    '{3'd5, 7'd20,  1'b1, 1'b0, 7'd0,  1'b0, 1'b1, 7'd10,  1'b0}, // R2 deactivate 20
    '{3'd2, 7'd10,  1'b1, 1'b0, 7'd0,  1'b0, 1'b0, 7'd0,   1'b0}, // R2 disable 10
    '{3'd1, 7'd111, 1'b1, 1'b0, 7'd0,  1'b0, 1'b0, 7'd0,   1'b0}, // R2 enable top
    '{3'd3, 7'd111, 1'b1, 1'b0, 7'd0,  1'b0, 1'b1, 7'd111, 1'b0}, // R6 top level vector
    '{3'd1, 7'd10,  1'b1, 1'b0, 7'd0,  1'b0, 1'b1, 7'd10,  1'b0}, // R5 10 beats 111
    '{3'd2, 7'd0,   1'b1, 1'b0, 7'd0,  1'b0, 1'b1, 7'd10,  1'b0}, // R9 disable 0 ignored
    '{3'd3, 7'd1,   1'b1, 1'b0, 7'd0,  1'b0, 1'b1, 7'd10,  1'b0}, // R9 request 1 ignored
    '{3'd4, 7'd0,   1'b1, 1'b0, 7'd0,  1'b0, 1'b1, 7'd10,  1'b0}, // R9 activate 0 ignored
    '{3'd3, 7'd1,   1'b0, 1'b0, 7'd0,  1'b0, 1'b1, 7'd10,  1'b1}, // R8 unpriv on protected
    '{3'd0, 7'd0,   1'b1, 1'b1, 7'd1,  1'b0, 1'b1, 7'd1,   1'b0}, // R9 hw 1 enabled
    '{3'd0, 7'd0,   1'b1, 1'b0, 7'd0,  1'b1, 1'b0, 7'd0,   1'b0}, // R10 ack 1
    '{3'd5, 7'd1,   1'b1, 1'b0, 7'd0,  1'b0, 1'b0, 7'd0,   1'b0}, // R10 deactivate ignored
    '{3'd0, 7'd0,   1'b1, 1'b1, 7'd0,  1'b0, 1'b1, 7'd0,   1'b0}, // R10 level 0 outranks
    '{3'd0, 7'd0,   1'b1, 1'b0, 7'd0,  1'b1, 1'b0, 7'd0,   1'b0}, // R10 ack 0
    '{3'd5, 7'd0,   1'b1, 1'b0, 7'd0,  1'b0, 1'b0, 7'd0,   1'b0}  // R10 stays held
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [6:0] lvl, input logic priv,
                      input logic hw, input logic [6:0] hwl, input logic ack);
    @(negedge clk);
    cmd_valid = (op != 3'd0);
    cmd_op    = op;
    cmd_level = lvl;
    cmd_priv  = priv;
    hw_req    = '0;
    if (hw) hw_req[hwl] = 1'b1;
    irq_ack   = ack;
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    cmd_op    = '0;
    hw_req    = '0;
    irq_ack   = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    check("R1 valid at reset", int'(irq_valid), 0);
    check("R1 trap at reset", int'(priv_trap), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 valid after release", int'(irq_valid), 0);

    for (int i = 0; i < NV; i++) begin
      step(VT[i].op, VT[i].lvl, VT[i].priv, VT[i].hw, VT[i].hwl, VT[i].ack);
      check($sformatf("R5 valid step %0d", i), int'(irq_valid), int'(VT[i].ev));
      check($sformatf("R8 trap step %0d", i), int'(priv_trap), int'(VT[i].et));
      if (VT[i].ev) begin
        check($sformatf("R5 level step %0d", i), int'(irq_level), int'(VT[i].el));
        check($sformatf("R6 vector step %0d", i), int'(irq_vector),
              int'(BASE) + 4 * int'(VT[i].el));
      end
    end

    // R1: mid-run reset clears held protected level and pending 10/111
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 valid in reset", int'(irq_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(3'd1, 7'd10, 1'b1, 1'b0, 7'd0, 1'b0);
    check("R1 pending cleared by reset", int'(irq_valid), 0);
    step(3'd2, 7'd10, 1'b1, 1'b0, 7'd0, 1'b0);
    step(3'd0, 7'd0, 1'b1, 1'b1, 7'd12, 1'b0);
    check("R1 level disabled after reset", int'(irq_valid), 0);
    step(3'd1, 7'd12, 1'b1, 1'b0, 7'd0, 1'b0);
    check("R4 kept across enable", int'(irq_valid), 1);
    check("R4 level", int'(irq_level), 12);
    check("R6 vector level 12", int'(irq_vector), int'(BASE) + 48);
    // R3: held hw line re-pends after ack, but active blocks it
    step(3'd0, 7'd0, 1'b1, 1'b1, 7'd12, 1'b1);
    check("R7 self blocked while active", int'(irq_valid), 0);
    step(3'd5, 7'd12, 1'b1, 1'b0, 7'd0, 1'b0);
    check("R3 re-pended by held line", int'(irq_valid), 1);
    check("R3 level", int'(irq_level), 12);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule